// File: doc/BRIEF.md
# ROM Select Stretcher with Video Pattern Capture

This block produces the active-low memory selects for the video and logic chip of a small Z80-style home computer rebuilt in programmable logic. A ROM select and a RAM select are decoded combinationally from the memory-request strobe and the high address line. Both follow the strobe directly for ordinary accesses.

During a display-file fetch the ROM select is held past the end of the request. It releases on the next rising edge of the CPU clock. On that same edge the eight data bits on the bus are latched as the next video pattern byte, and a load strobe tells the shift register that a new byte is ready.

All timing comes from CPU clock edges, so the block keeps working when the clock rate changes. A RAM request that arrives while the ROM select is still held is not granted until that hold ends, so the two selects never overlap. A request is taken into account only if it is present at a rising clock edge.

Top module: `rom_select_stretch`

## Requirements
- R1: Out of reset, `romSelN` is low whenever `memReqN` is low and `addrHigh` is low.
- R2: With no ROM hold pending, `ramSelN` is low while `memReqN` is low and `addrHigh` is high. It goes high in the same cycle that `memReqN` goes high.
- R3: A ROM request seen at a rising edge with `dispFetch` high keeps `romSelN` low after `memReqN` returns high. The hold lasts until the next rising edge, and `romSelN` is high after that edge.
- R4: A ROM request with `dispFetch` low is not held. `romSelN` goes high in the same cycle that `memReqN` goes high.
- R5: On the rising edge that ends a ROM hold, `dataIn` is latched onto `patternOut`. `videoLoad` is then high for exactly one cycle.
- R6: `romSelN` and `ramSelN` are never low at the same time.
- R7: A RAM request made while a ROM hold is pending keeps `ramSelN` high until the edge that ends the hold. `ramSelN` goes low in the cycle after that edge.
- R8: While `rstN` is low, both selects are high and `videoLoad` is low. A pending hold is cleared, and `patternOut` resets to 0x00.
- R9: `patternOut` keeps its value across ordinary ROM fetches, RAM accesses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; every hold release and capture happens on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| memReqN | input | 1 | Active-low memory request strobe |
| addrHigh | input | 1 | Address line that chooses RAM (high) or ROM (low) |
| dispFetch | input | 1 | High during a display-file fetch cycle |
| dataIn | input | DATA_W | Data bus, captured as the video pattern |
| romSelN | output | 1 | Active-low ROM chip select |
| ramSelN | output | 1 | Active-low RAM chip select |
| videoLoad | output | 1 | One-cycle pulse after a new pattern byte is latched |
| patternOut | output | DATA_W | Last captured pattern byte |

## Verification
The only hidden state is a single hold flag. If it is wrong, the fault shows at the ports within one clock cycle. A flag that is never set makes `romSelN` rise together with `memReqN`, and no `videoLoad` pulse follows. A flag that sticks keeps `romSelN` low and blocks `ramSelN` on the next RAM access. A capture on the wrong edge latches a byte the bench drives on a different cycle, so `patternOut` shows the error in the cycle after the hold ends.

// File: rtl/rom_select_pkg.sv
package rom_select_pkg;
  // Strobes sent from the select control to the pattern datapath.
  typedef struct packed {
    logic capture;   // this rising edge ends a ROM hold
  } csStrobes_t;
endpackage

// File: rtl/rom_select_ctrl.sv
module rom_select_ctrl
  import rom_select_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       memReqN,
  input  logic       addrHigh,
  input  logic       dispFetch,
  output logic       romSelN,
  output logic       ramSelN,
  output csStrobes_t strobes
);
  logic romReq;
  logic ramReq;
  logic romHold;

  assign romReq = rstN & ~memReqN & ~addrHigh;
  assign ramReq = rstN & ~memReqN &  addrHigh;

  // The hold flag is set by a display ROM request seen at a rising edge.
  // It clears on the first edge at which that request is gone.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) romHold <= 1'b0;
    else       romHold <= romReq & dispFetch;
  end

  assign romSelN         = ~(romReq | (rstN & romHold));
  assign ramSelN         = ~(ramReq & ~romHold);
  assign strobes.capture = romHold & ~romReq;

  assert_rom_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && !addrHigh) |-> !romSelN);

  assert_sel_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!romSelN && !ramSelN));

  assert_hold_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!romSelN && memReqN) ##1 memReqN |-> romSelN);

  assert_ram_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!romSelN && !memReqN && addrHigh) |-> ramSelN);
endmodule

// File: rtl/rom_select_dpath.sv
module rom_select_dpath
  import rom_select_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobes_t        strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic              videoLoad,
  output logic [DATA_W-1:0] patternOut
);
  logic [DATA_W-1:0] patternReg;
  logic              loadReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patternReg <= '0;
      loadReg    <= 1'b0;
    end else begin
      loadReg <= strobes.capture;
      if (strobes.capture) patternReg <= dataIn;
    end
  end

  assign videoLoad  = loadReg;
  assign patternOut = patternReg;

  assert_load_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    videoLoad |=> !videoLoad);

  assert_pattern_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !videoLoad |-> $stable(patternOut) || $rose(videoLoad));
endmodule

// File: rtl/rom_select_stretch.sv
module rom_select_stretch
  import rom_select_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReqN,
  input  logic              addrHigh,
  input  logic              dispFetch,
  input  logic [DATA_W-1:0] dataIn,
  output logic              romSelN,
  output logic              ramSelN,
  output logic              videoLoad,
  output logic [DATA_W-1:0] patternOut
);
  csStrobes_t strobes;

  rom_select_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .memReqN(memReqN), .addrHigh(addrHigh),
    .dispFetch(dispFetch), .romSelN(romSelN), .ramSelN(ramSelN),
    .strobes(strobes)
  );

  rom_select_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .videoLoad(videoLoad), .patternOut(patternOut)
  );
endmodule

// File: tb/rom_select_stretch_tb.sv
module rom_select_stretch_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       memReqN = 1'b1;
  logic       addrHigh = 1'b0;
  logic       dispFetch = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       romSelN, ramSelN, videoLoad;
  logic [7:0] patternOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rom_select_stretch #(.DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .memReqN(memReqN), .addrHigh(addrHigh),
    .dispFetch(dispFetch), .dataIn(dataIn), .romSelN(romSelN),
    .ramSelN(ramSelN), .videoLoad(videoLoad), .patternOut(patternOut)
  );

  typedef struct packed {
    logic       mreqN;
    logic       aHigh;
    logic       disp;
    logic [7:0] data;
    logic       expRomN;
    logic       expRamN;
    logic       expLoad;
    logic [7:0] expPat;
  } vec_t;

  localparam int NVEC = 14;
  // Inputs are driven at the falling edge and checked 1 ns later.
  // Registered outputs show the result of the rising edge before.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00},  // R8 idle after reset
    '{1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 8'h00},  // R1 display ROM request
    '{1'b1, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 8'h00},  // R3 held past the strobe
    '{1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hA5},  // R3 released, R5 load
    '{1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hA5},  // R5 single pulse
    '{1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 8'hA5},  // R1 ordinary fetch
    '{1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 8'hA5},  // R4 no hold
    '{1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 8'hA5},  // R9 pattern kept
    '{1'b0, 1'b1, 1'b0, 8'h77, 1'b1, 1'b0, 1'b0, 8'hA5},  // R2 RAM select
    '{1'b1, 1'b1, 1'b0, 8'h77, 1'b1, 1'b1, 1'b0, 8'hA5},  // R2 immediate release, R9
    '{1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 8'hA5},  // R1 second display fetch
    '{1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 8'hA5},  // R7 RAM held off, R6
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h5A},  // R7 granted, R5 load
    '{1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h5A}   // R5 pulse over
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic a, input logic d, input logic [7:0] v);
    @(negedge clk);
    memReqN = m; addrHigh = a; dispFetch = d; dataIn = v;
    #1;
  endtask

  initial begin
    #1;
    check("R8 romSelN in reset", {7'd0, romSelN}, 8'h01);
    check("R8 ramSelN in reset", {7'd0, ramSelN}, 8'h01);
    check("R8 videoLoad in reset", {7'd0, videoLoad}, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].mreqN, VECS[i].aHigh, VECS[i].disp, VECS[i].data);
      check($sformatf("R1-6 vec%0d romSelN", i), {7'd0, romSelN}, {7'd0, VECS[i].expRomN});
      check($sformatf("R2/R7 vec%0d ramSelN", i), {7'd0, ramSelN}, {7'd0, VECS[i].expRamN});
      check($sformatf("R5 vec%0d videoLoad", i), {7'd0, videoLoad}, {7'd0, VECS[i].expLoad});
      check($sformatf("R9 vec%0d patternOut", i), patternOut, VECS[i].expPat);
      check($sformatf("R6 vec%0d exclusive", i), {7'd0, romSelN | ramSelN}, 8'h01);
    end
    // R8: a reset during a pending hold releases the ROM select at once.
    drive(1'b0, 1'b0, 1'b1, 8'hC3);
    drive(1'b1, 1'b0, 1'b1, 8'hC3);
    check("R3 hold before reset", {7'd0, romSelN}, 8'h00);
    rstN = 1'b0;
    #0.5;
    check("R8 romSelN released by reset", {7'd0, romSelN}, 8'h01);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R8 pattern cleared", patternOut, 8'h00);
    check("R8 no load after reset", {7'd0, videoLoad}, 8'h00);
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 hold cleared romSelN", {7'd0, romSelN}, 8'h01);
    check("R8 no stale capture", patternOut, 8'h00);
    // R4: an ordinary fetch does not latch the bus.
    drive(1'b0, 1'b0, 1'b0, 8'h99);
    drive(1'b1, 1'b0, 1'b0, 8'h99);
    check("R4 ordinary release", {7'd0, romSelN}, 8'h01);
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    check("R9 no capture on ordinary fetch", patternOut, 8'h00);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule